// File: doc/BRIEF.md
# Ping-Pong Swing Buffer Controller

This block steers a continuous stream of 32-bit sample-pair words into two alternating memory banks. Words go into the active bank at consecutive addresses. When the programmed number of words has been written, the controller resets its word counter and hands that bank to the host. The other bank then becomes the write target. Every hand-over raises a buffer-swap event. A second event input, transfer-complete, comes from an external mover. Both events are latched in sticky status bits. A per-source enable register gates them onto a single interrupt line.

The host drives the block through a small register port, which has a combinational read path. In diagnostic mode the sample stream is blocked. Instead, each host write to a data register becomes a buffer write. These writes use the same addressing and bank swapping as live samples, so the whole path can be exercised without converters. The RAM itself and any bus protocol sit outside the block. The write-port outputs are meant to drive a two-bank RAM directly, and the host reads the bank named by `readBank`.

Top module: `swingBufCtl`

## Requirements
- R1: After reset the write bank is 0, the word counter is 0, `memWe` and `irq` are low, `readBank` is 1, and every register reads zero.
- R2: An accepted word drives `memWe` high in the same cycle. `memWdata` carries the word, `memAddr` equals the current word count and `memBank` equals the current bank. With an effective length L, the n-th word since the pointer was cleared lands at address n mod L in bank (n / L) mod 2.
- R3: On the clock edge that takes the L-th word of a bank, the counter reloads to 0 and the bank toggles at the same edge. `readBank` is always the complement of `memBank`. A programmed length of 0 acts as a length of 1.
- R4: Each swap sets status bit 1, and a one-cycle `xferDone` pulse sets status bit 0. Both bits stay set until the host clears them, whether or not they are enabled. Status is at register address 2.
- R5: Status bit 2 reads as the OR of status bits 1 and 0.
- R6: `irq` is high exactly when some status bit is set and its enable bit is set. The enable register is at address 3: bit 0 for transfer-complete, bit 1 for swap. A source whose enable bit is clear never raises `irq`.
- R7: Writing a 1 to status bit 0 or 1 clears that bit, and writing 0 leaves it unchanged. If an event and a clearing write for the same bit fall in one cycle, the bit ends up set.
- R8: The control register is at address 0, with bit 0 for run and bit 1 for diagnostic. In diagnostic mode, sample inputs produce no buffer write. Each host write to address 4 produces one buffer write carrying the host data, and it advances the counter and swaps banks like a sample.
- R9: With run clear and diagnostic clear, sample inputs produce no buffer write and leave the pointer unchanged.
- R10: Register bits that have no function read 0. Addresses 4, 6 and 7 read 0. The length register (address 1) keeps only its low LEN_W bits, and the control and enable registers keep only two bits.
- R11: Any write to address 5 clears the counter and selects bank 0. A sample arriving in the same cycle is discarded. A read of address 5 returns the counter in the low LEN_W bits and the bank in bit LEN_W.
- R12: If the length is reduced to a value at or below the current count, the next accepted word is written at the current address and then triggers a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smpValid | input | 1 | Sample-pair word present |
| smpData | input | DATA_W | Sample-pair word |
| xferDone | input | 1 | One-cycle transfer-complete event |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register address |
| regWdata | input | DATA_W | Host write data |
| regRdata | output | DATA_W | Host read data for regAddr |
| memWe | output | 1 | Buffer write enable |
| memBank | output | 1 | Bank receiving writes |
| memAddr | output | LEN_W | Word address within the bank |
| memWdata | output | DATA_W | Buffer write data |
| readBank | output | 1 | Bank the host may read |
| irq | output | 1 | Interrupt request |

## Verification
Three kinds of event can land on the same clock edge: a bank swap, a transfer-complete pulse and a host write that clears status. The bench drives the last word of a length-1 bank, an `xferDone` pulse and a write of ones to the status register, all in one cycle. It then expects all three status bits to read back as one. A second collision is a pointer-clear write that lands together with a valid sample. In that case `memWe` must stay low within the cycle, and the pointer must read back as zero afterwards.

// File: rtl/swingBufPkg.sv
package swingBufPkg;
  // register addresses on the host port
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_LEN  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_IEN  = 3'd3;
  localparam logic [2:0] A_DIAG = 3'd4;
  localparam logic [2:0] A_PTR  = 3'd5;

  localparam int unsigned NSRC = 2;  // event sources: 0 transfer, 1 swap

  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;    // one buffer write this cycle
    logic useHost;  // data comes from host, not the stream
    logic ptrClr;   // clear counter and bank
  } bufStbT;
endpackage

// File: rtl/swingBufCtlCtrl.sv
module swingBufCtlCtrl
  import swingBufPkg::*;
#(
  parameter int unsigned LEN_W  = 19,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smpValid,
  input  logic              xferDone,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              swapEv,
  input  logic [LEN_W-1:0]  ptrCount,
  input  logic              ptrBank,
  output bufStbT            stb,
  output logic [LEN_W-1:0]  lenQ,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic              diagOn,
  output logic [NSRC-1:0]   statQ,
  output logic [NSRC-1:0]   ienQ
);
  logic runOn;
  logic hostDataWr, ptrWr, statWr;
  logic [NSRC-1:0] setVec;

  assign hostDataWr = regWe && (regAddr == A_DIAG);
  assign ptrWr      = regWe && (regAddr == A_PTR);
  assign statWr     = regWe && (regAddr == A_STAT);
  assign setVec     = {swapEv, xferDone};

  // pointer clear beats any coincident write
  always_comb begin
    stb.ptrClr  = ptrWr;
    stb.useHost = diagOn;
    stb.wrStb   = !ptrWr && (diagOn ? hostDataWr : (runOn && smpValid));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runOn  <= 1'b0;
      diagOn <= 1'b0;
      lenQ   <= '0;
      ienQ   <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_CTRL: {diagOn, runOn} <= regWdata[1:0];
        A_LEN:  lenQ <= regWdata[LEN_W-1:0];
        A_IEN:  ienQ <= regWdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  // sticky status, write-one-to-clear, set has priority
  for (genvar i = 0; i < NSRC; i++) begin : gStat
    always_ff @(posedge clk) begin
      if (!rstN)
        statQ[i] <= 1'b0;
      else if (setVec[i])
        statQ[i] <= 1'b1;
      else if (statWr && regWdata[i])
        statQ[i] <= 1'b0;
    end
  end

  assign irq = |(statQ & ienQ);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL: regRdata[1:0]       = {diagOn, runOn};
      A_LEN:  regRdata[LEN_W-1:0] = lenQ;
      A_STAT: regRdata[NSRC:0]    = {|statQ, statQ};
      A_IEN:  regRdata[NSRC-1:0]  = ienQ;
      A_PTR:  regRdata[LEN_W:0]   = {ptrBank, ptrCount};
      default: ;
    endcase
  end
endmodule

// File: rtl/swingBufCtlPath.sv
module swingBufCtlPath
  import swingBufPkg::*;
#(
  parameter int unsigned LEN_W  = 19,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStbT            stb,
  input  logic [DATA_W-1:0] smpData,
  input  logic [DATA_W-1:0] hostData,
  input  logic [LEN_W-1:0]  lenQ,
  output logic              memWe,
  output logic              memBank,
  output logic [LEN_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              swapEv,
  output logic [LEN_W-1:0]  countQ,
  output logic              bankQ
);
  logic [LEN_W-1:0] lastIdx;
  logic             atLast;

  // length 0 behaves as 1; >= also covers a length cut below the count
  assign lastIdx = (lenQ == '0) ? '0 : lenQ - LEN_W'(1);
  assign atLast  = countQ >= lastIdx;
  assign swapEv  = stb.wrStb && atLast;

  assign memWe    = stb.wrStb;
  assign memAddr  = countQ;
  assign memBank  = bankQ;
  assign memWdata = stb.useHost ? hostData : smpData;

  always_ff @(posedge clk) begin
    if (!rstN || stb.ptrClr) begin
      countQ <= '0;
      bankQ  <= 1'b0;
    end else if (stb.wrStb) begin
      if (atLast) begin
        countQ <= '0;
        bankQ  <= ~bankQ;
      end else begin
        countQ <= countQ + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/swingBufCtl.sv
module swingBufCtl
  import swingBufPkg::*;
#(
  parameter int unsigned LEN_W  = 19,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smpValid,
  input  logic [DATA_W-1:0] smpData,
  input  logic              xferDone,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memWe,
  output logic              memBank,
  output logic [LEN_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              readBank,
  output logic              irq
);
  bufStbT           stb;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] countQ;
  logic             bankQ;
  logic             swapEv;
  logic             diagOn;
  logic [NSRC-1:0]  statQ;
  logic [NSRC-1:0]  ienQ;

  swingBufCtlCtrl #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .xferDone(xferDone),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .swapEv(swapEv), .ptrCount(countQ), .ptrBank(bankQ),
    .stb(stb), .lenQ(lenQ), .regRdata(regRdata), .irq(irq),
    .diagOn(diagOn), .statQ(statQ), .ienQ(ienQ)
  );

  swingBufCtlPath #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .smpData(smpData),
    .hostData(regWdata), .lenQ(lenQ), .memWe(memWe), .memBank(memBank),
    .memAddr(memAddr), .memWdata(memWdata), .swapEv(swapEv),
    .countQ(countQ), .bankQ(bankQ)
  );

  assign readBank = ~bankQ;
endmodule

// File: rtl/swingBufChk.sv
module swingBufChk #(
  parameter int unsigned LEN_W  = 19,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              memWe,
  input logic              memBank,
  input logic              irq,
  input logic              diagOn,
  input logic [1:0]        statQ,
  input logic [1:0]        ienQ,
  input logic [LEN_W-1:0]  countQ
);
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == 2'b00) |-> !irq);

  p_swap_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[1] && !(regWe && regAddr == 3'd2)) |=> statQ[1]);

  p_xfer_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[0] && !(regWe && regAddr == 3'd2)) |=> statQ[0]);

  p_swap_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((memBank != $past(memBank)) && !$past(regWe && regAddr == 3'd5)) |-> statQ[1]);

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((memBank != $past(memBank)) && !$past(regWe && regAddr == 3'd5)) |-> (countQ == '0));

  p_diag_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (diagOn && !(regWe && regAddr == 3'd4)) |-> !memWe);

  p_agg_or_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd2) |-> (regRdata[2] == (regRdata[1] | regRdata[0])));

  p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd4 || regAddr == 3'd6 || regAddr == 3'd7) |-> (regRdata == '0));
endmodule

bind swingBufCtl swingBufChk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regRdata(regRdata), .memWe(memWe), .memBank(memBank), .irq(irq),
  .diagOn(diagOn), .statQ(statQ), .ienQ(ienQ), .countQ(countQ)
);

// File: tb/swingBufCtl_test.sv
module swingBufCtl_test;
  localparam int LW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          smpValid, xferDone, regWe;
  logic [DW-1:0] smpData, regWdata, regRdata, memWdata;
  logic [2:0]    regAddr;
  logic          memWe, memBank, readBank, irq;
  logic [LW-1:0] memAddr;

  int total = 0;
  int bad   = 0;
  logic [31:0] v, d;
  int eff;

  always #5 clk = ~clk;

  swingBufCtl #(.LEN_W(LW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .smpValid(smpValid), .smpData(smpData),
    .xferDone(xferDone), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memWe(memWe),
    .memBank(memBank), .memAddr(memAddr), .memWdata(memWdata),
    .readBank(readBank), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] x);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = x;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] x);
    @(negedge clk); regAddr = a; #1 x = regRdata;
  endtask

  task automatic sampleOn(input logic [31:0] x);
    @(negedge clk); smpValid = 1'b1; smpData = x; #1;
  endtask

  task automatic idleNext();
    @(negedge clk); smpValid = 1'b0; regWe = 1'b0; xferDone = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0; smpValid = 1'b0; xferDone = 1'b0; regWe = 1'b0;
    regAddr = 3'd0; regWdata = '0; smpData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1 memWe", {31'b0, memWe}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 memBank", {31'b0, memBank}, 0);
    check("R1 readBank", {31'b0, readBank}, 1);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg zero", v, 0);
    end

    // R2 R3 sweep over every length, including 0
    for (int L = 0; L < 16; L++) begin
      eff = (L == 0) ? 1 : L;
      wr(3'd5, 0); wr(3'd2, 3); wr(3'd1, L); wr(3'd0, 1);
      for (int n = 0; n < 2 * eff + 3; n++) begin
        d = 32'hA500_0000 + (L << 8) + n;
        sampleOn(d);
        check("R2 we", {31'b0, memWe}, 1);
        check("R2 addr", {28'b0, memAddr}, n % eff);
        check("R3 bank", {31'b0, memBank}, (n / eff) % 2);
        check("R2 data", memWdata, d);
        check("R3 readBank", {31'b0, readBank}, 1 - ((n / eff) % 2));
        idleNext();
      end
      rd(3'd2, v);
      check("R4 swap flag", {31'b0, v[1]}, 1);
    end
    wr(3'd0, 0);

    // R12 length cut below current count
    wr(3'd5, 0); wr(3'd1, 8); wr(3'd0, 1);
    for (int n = 0; n < 5; n++) begin sampleOn(n); idleNext(); end
    wr(3'd1, 3);
    sampleOn(32'h55);
    check("R12 addr", {28'b0, memAddr}, 5);
    check("R12 bank", {31'b0, memBank}, 0);
    idleNext();
    rd(3'd5, v);
    check("R12 swapped ptr", v, 32'h10);

    // R11 pointer clear beats a coincident sample
    sampleOn(32'h66);
    regWe = 1'b1; regAddr = 3'd5; regWdata = 0; #1;
    check("R11 sample dropped", {31'b0, memWe}, 0);
    idleNext();
    rd(3'd5, v);
    check("R11 ptr cleared", v, 0);

    // R9 run off
    wr(3'd0, 0);
    sampleOn(32'h77);
    check("R9 no write", {31'b0, memWe}, 0);
    idleNext();
    rd(3'd5, v);
    check("R9 ptr held", v, 0);

    // R8 diagnostic path
    wr(3'd1, 2); wr(3'd0, 3);
    sampleOn(32'h88);
    check("R8 stream blocked", {31'b0, memWe}, 0);
    idleNext();
    for (int n = 0; n < 2; n++) begin
      @(negedge clk); regWe = 1'b1; regAddr = 3'd4; regWdata = 32'hD1A0 + n; #1;
      check("R8 host we", {31'b0, memWe}, 1);
      check("R8 host data", memWdata, 32'hD1A0 + n);
      check("R8 host addr", {28'b0, memAddr}, n);
      @(negedge clk); regWe = 1'b0;
    end
    rd(3'd5, v);
    check("R8 diag swap", v, 32'h10);
    wr(3'd0, 0);

    // R4 R5 R7 sticky status and write-one-to-clear
    wr(3'd2, 3); wr(3'd3, 0);
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    rd(3'd2, v);
    check("R4 xfer sticky masked", v, 5);
    check("R5 aggregate", {31'b0, v[2]}, 1);
    check("R6 masked no irq", {31'b0, irq}, 0);
    wr(3'd2, 0); rd(3'd2, v);
    check("R7 zero write keeps", v, 5);
    wr(3'd2, 2); rd(3'd2, v);
    check("R7 other bit clear keeps", v, 5);
    wr(3'd2, 1); rd(3'd2, v);
    check("R7 clear", v, 0);

    // R7 set wins over clear in the same cycle (both sources)
    wr(3'd5, 0); wr(3'd1, 1); wr(3'd0, 1);
    sampleOn(32'h99);
    regWe = 1'b1; regAddr = 3'd2; regWdata = 3; xferDone = 1'b1;
    idleNext();
    rd(3'd2, v);
    check("R7 set beats clear", v, 7);
    wr(3'd0, 0);

    // R6 irq gating, only swap bit set
    wr(3'd2, 1); rd(3'd2, v);
    check("R5 aggregate swap only", v, 6);
    wr(3'd3, 1); #1;
    check("R6 swap masked", {31'b0, irq}, 0);
    wr(3'd3, 2); #1;
    check("R6 swap enabled", {31'b0, irq}, 1);
    wr(3'd3, 0); #1;
    check("R6 all masked", {31'b0, irq}, 0);

    // R10 undefined bits read zero
    wr(3'd0, 32'hFFFF_FFFC); rd(3'd0, v);
    check("R10 ctrl width", v, 0);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v);
    check("R10 len width", v, 32'hF);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v);
    check("R10 ien width", v, 3);
    wr(3'd3, 0);
    rd(3'd2, v);
    check("R10 stat upper", v & ~32'h7, 0);
    rd(3'd4, v); check("R10 addr4", v, 0);
    rd(3'd6, v); check("R10 addr6", v, 0);
    rd(3'd7, v); check("R10 addr7", v, 0);

    summary();
  end
endmodule